// File: doc/BRIEF.md
# Speculative Fill Shadow Buffer

This block keeps the cache-visible footprint of speculative memory accesses away from a shared cache until the speculation that issued them resolves. Each hardware thread owns a private set of entries. A speculative access arrives with a thread number, a speculation epoch number, a line address and the line's data. It is recorded in that thread's entries and nothing is written toward the shared cache.

The branch-resolution side names a (thread, epoch) pair to commit or to squash. Committed entries are replayed onto a shared-cache write port one line per cycle, oldest allocation first, so the replay order depends only on allocation order and never on data. Squashed entries vanish in one cycle and are never replayed. A non-speculative lookup answers after a fixed number of cycles whether a committed, not yet replayed line of that thread holds the address. Speculative lines are never visible to it.

The request stream uses valid/ready. A speculative request is back-pressured while its thread's entries are all occupied. A non-speculative request is always accepted. The replay port is valid/ready as well: once `sc_valid` is high, the line stays unchanged until `sc_ready` is seen high at a clock edge. The commit input has a ready that is low while a squash is presented, and the resolution logic must hold the commit until it is accepted.

Top module: `spec_shadow_buf`

## Requirements
- R1: Each thread's entries are separate. A commit, squash or lookup naming thread t never touches, replays or reports an entry of another thread, and a full thread never stalls another thread's requests.
- R2: An accepted speculative request places nothing on the replay port until its (thread, epoch) is committed. Only committed entries are ever replayed.
- R3: With DEPTH (8) occupied entries in thread t, a speculative request for t has `req_ready` low. A non-speculative request always has `req_ready` high. Space freed by a squash or a replay makes `req_ready` high in the following cycle.
- R4: Committed entries are replayed one per accepted transfer in allocation order, oldest first, across all epochs committed so far. When several threads have a line ready, the lower thread number is loaded first.
- R5: A squash of (t, e) removes every uncommitted entry of thread t with epoch e at one clock edge. None of them is ever replayed or returned by a lookup.
- R6: If a squash and a commit are presented in the same cycle, `cmt_ready` is low, the squash takes effect and the commit is not applied in that cycle.
- R7: A non-speculative request accepted in cycle c yields `rsp_valid` high in exactly cycle c+HIT_LAT (2), with `rsp_hit`=1 and the line data if a committed, not yet replayed entry of that thread holds the address, and `rsp_hit`=0 otherwise. An uncommitted entry gives `rsp_hit`=0.
- R8: While `sc_valid` is high and `sc_ready` is low, `sc_valid`, `sc_tid`, `sc_addr` and `sc_data` stay unchanged. A line leaves the entries when it is loaded into the replay register.
- R9: After reset there are no entries, `sc_valid` and `rsp_valid` are low, and `req_ready` and `cmt_ready` are high.
- R10: A speculative request accepted in the same cycle as a squash of its own (thread, epoch) is dropped. One accepted in the same cycle as a commit of its own (thread, epoch) is stored as committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Access request accepted |
| req_spec | input | 1 | 1: speculative access, 0: non-speculative lookup |
| req_tid | input | TID_W (1) | Issuing thread |
| req_epoch | input | EPOCH_W (4) | Speculation epoch of the access |
| req_addr | input | ADDR_W (16) | Line address |
| req_data | input | DATA_W (32) | Line data fetched for a speculative access |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup found a committed line |
| rsp_data | output | DATA_W (32) | Line data on a hit, zero otherwise |
| cmt_valid | input | 1 | Commit an epoch |
| cmt_ready | output | 1 | Commit accepted |
| cmt_tid | input | TID_W (1) | Thread of the commit |
| cmt_epoch | input | EPOCH_W (4) | Epoch being committed |
| sqh_valid | input | 1 | Squash an epoch (always accepted) |
| sqh_tid | input | TID_W (1) | Thread of the squash |
| sqh_epoch | input | EPOCH_W (4) | Epoch being squashed |
| sc_valid | output | 1 | Replay line to the shared cache valid |
| sc_ready | input | 1 | Shared cache accepts the replay line |
| sc_tid | output | TID_W (1) | Thread that owned the line |
| sc_addr | output | ADDR_W (16) | Replayed line address |
| sc_data | output | DATA_W (32) | Replayed line data |

## Verification
Two pairs of functions can meet in one cycle. A squash and a commit can be presented together, and a speculative allocation can coincide with the squash or commit of its own epoch. The bench drives each pair at the same falling edge. It judges the first by `cmt_ready` being low, by the absence of any replay afterwards and by a lookup miss on the committed-epoch line. It judges the second by whether the new line later appears on the replay port and whether it holds there under back-pressure.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_SPEC = 2'd1,
    SLOT_DONE = 2'd2
  } slot_state_e;
endpackage

// File: rtl/ssb_age_matrix.sv
module ssb_age_matrix #(
  parameter int DEPTH = 8,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_en,
  input  logic [IW-1:0]    alloc_idx,
  input  logic [DEPTH-1:0] occupied,
  input  logic [DEPTH-1:0] cand,
  output logic [DEPTH-1:0] oldest,
  output logic             oldest_any
);
  // ahead_q[i][j] = 1 means slot j was allocated before slot i
  logic [DEPTH-1:0] ahead_q [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ahead_q[i] <= '0;
    end else if (alloc_en) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (IW'(i) == alloc_idx) ahead_q[i] <= occupied;
        else                     ahead_q[i][alloc_idx] <= 1'b0;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      oldest[i] = cand[i] && !(|(ahead_q[i] & cand));
    oldest_any = |oldest;
  end

  // a consistent age order picks at most one oldest candidate
  assert_oldest_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(oldest));
  assert_oldest_exists_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|cand) |-> oldest_any);
endmodule

// File: rtl/ssb_rsp_pipe.sv
module ssb_rsp_pipe #(
  parameter int LAT    = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_hit,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic              out_hit,
  output logic [DATA_W-1:0] out_data
);
  logic              v_q [LAT];
  logic              h_q [LAT];
  logic [DATA_W-1:0] d_q [LAT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < LAT; s++) begin
        v_q[s] <= 1'b0;
        h_q[s] <= 1'b0;
        d_q[s] <= '0;
      end
    end else begin
      v_q[0] <= in_valid;
      h_q[0] <= in_valid && in_hit;
      d_q[0] <= (in_valid && in_hit) ? in_data : '0;
      for (int s = 1; s < LAT; s++) begin
        v_q[s] <= v_q[s-1];
        h_q[s] <= h_q[s-1];
        d_q[s] <= d_q[s-1];
      end
    end
  end

  assign out_valid = v_q[LAT-1];
  assign out_hit   = h_q[LAT-1];
  assign out_data  = d_q[LAT-1];

  assert_hit_needs_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_hit |-> out_valid);
endmodule

// File: rtl/ssb_thread_buf.sv
module ssb_thread_buf
  import ssb_pkg::*;
#(
  parameter int THREAD_ID = 0,
  parameter int DEPTH     = 8,
  parameter int TID_W     = 1,
  parameter int EPOCH_W   = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 32,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_en,
  input  logic [TID_W-1:0]   alloc_tid,
  input  logic [EPOCH_W-1:0] alloc_epoch,
  input  logic [ADDR_W-1:0]  alloc_addr,
  input  logic [DATA_W-1:0]  alloc_data,
  input  logic               cmt_en,
  input  logic [EPOCH_W-1:0] cmt_epoch,
  input  logic               sqh_en,
  input  logic [EPOCH_W-1:0] sqh_epoch,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               lk_hit,
  output logic [DATA_W-1:0]  lk_data,
  output logic               full,
  output logic               drain_valid,
  output logic [TID_W-1:0]   drain_tid,
  output logic [ADDR_W-1:0]  drain_addr,
  output logic [DATA_W-1:0]  drain_data,
  input  logic               drain_take
);
  slot_state_e        st_q   [DEPTH];
  logic [TID_W-1:0]   tid_q  [DEPTH];
  logic [EPOCH_W-1:0] ep_q   [DEPTH];
  logic [ADDR_W-1:0]  addr_q [DEPTH];
  logic [DATA_W-1:0]  data_q [DEPTH];

  logic [DEPTH-1:0] occ_v, done_v, pick_v;
  logic [IW-1:0]    free_idx, pick_idx;
  logic             any_free, pick_any;
  logic             store_en, store_done;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      occ_v[i]  = (st_q[i] != SLOT_FREE);
      done_v[i] = (st_q[i] == SLOT_DONE);
      if (st_q[i] == SLOT_FREE) begin
        any_free = 1'b1;
        free_idx = IW'(i);
      end
    end
  end
  assign full = !any_free;

  // a line whose epoch is squashed at the same edge is never stored
  assign store_en   = alloc_en && !(sqh_en && sqh_epoch == alloc_epoch);
  assign store_done = cmt_en && cmt_epoch == alloc_epoch;

  ssb_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_en   (store_en),
    .alloc_idx  (free_idx),
    .occupied   (occ_v),
    .cand       (done_v),
    .oldest     (pick_v),
    .oldest_any (pick_any)
  );

  always_comb begin
    pick_idx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (pick_v[i]) pick_idx = IW'(i);
  end

  assign drain_valid = pick_any;
  assign drain_tid   = tid_q[pick_idx];
  assign drain_addr  = addr_q[pick_idx];
  assign drain_data  = data_q[pick_idx];

  always_comb begin
    lk_hit  = 1'b0;
    lk_data = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (st_q[i] == SLOT_DONE && addr_q[i] == lk_addr) begin
        lk_hit  = 1'b1;
        lk_data = data_q[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        st_q[i]   <= SLOT_FREE;
        tid_q[i]  <= '0;
        ep_q[i]   <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (drain_take && pick_v[i]) begin
          st_q[i] <= SLOT_FREE;
        end else if (st_q[i] == SLOT_SPEC && sqh_en && ep_q[i] == sqh_epoch) begin
          st_q[i] <= SLOT_FREE;
        end else if (st_q[i] == SLOT_SPEC && cmt_en && ep_q[i] == cmt_epoch) begin
          st_q[i] <= SLOT_DONE;
        end
      end
      if (store_en) begin
        st_q[free_idx]   <= store_done ? SLOT_DONE : SLOT_SPEC;
        tid_q[free_idx]  <= alloc_tid;
        ep_q[free_idx]   <= alloc_epoch;
        addr_q[free_idx] <= alloc_addr;
        data_q[free_idx] <= alloc_data;
      end
    end
  end

  // checking state: epoch of the last squash seen by this thread
  logic [EPOCH_W-1:0] last_sqh_q;
  logic               spec_left;
  always_ff @(posedge clk) begin
    if (!rst_n)      last_sqh_q <= '0;
    else if (sqh_en) last_sqh_q <= sqh_epoch;
  end
  always_comb begin
    spec_left = 1'b0;
    for (int i = 0; i < DEPTH; i++)
      if (st_q[i] == SLOT_SPEC && ep_q[i] == last_sqh_q) spec_left = 1'b1;
  end

  assert_squash_clears_all_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sqh_en |=> !spec_left);
  assert_replay_only_committed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> st_q[pick_idx] == SLOT_DONE);
  assert_no_alloc_when_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !full);
  assert_own_thread_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> alloc_tid == TID_W'(THREAD_ID));
endmodule

// File: rtl/spec_shadow_buf.sv
module spec_shadow_buf #(
  parameter int THREADS = 2,
  parameter int DEPTH   = 8,
  parameter int EPOCH_W = 4,
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int HIT_LAT = 2,
  localparam int TID_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_spec,
  input  logic [TID_W-1:0]   req_tid,
  input  logic [EPOCH_W-1:0] req_epoch,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_data,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [DATA_W-1:0]  rsp_data,
  input  logic               cmt_valid,
  output logic               cmt_ready,
  input  logic [TID_W-1:0]   cmt_tid,
  input  logic [EPOCH_W-1:0] cmt_epoch,
  input  logic               sqh_valid,
  input  logic [TID_W-1:0]   sqh_tid,
  input  logic [EPOCH_W-1:0] sqh_epoch,
  output logic               sc_valid,
  input  logic               sc_ready,
  output logic [TID_W-1:0]   sc_tid,
  output logic [ADDR_W-1:0]  sc_addr,
  output logic [DATA_W-1:0]  sc_data
);
  logic [THREADS-1:0] full_v, dv_v, take_v, hit_v;
  logic [TID_W-1:0]   dtid_a  [THREADS];
  logic [ADDR_W-1:0]  daddr_a [THREADS];
  logic [DATA_W-1:0]  ddata_a [THREADS];
  logic [DATA_W-1:0]  lkd_a   [THREADS];

  logic             sel_tid_full;
  logic             cmt_fire;
  logic             load_en, load_fire;
  logic [TID_W-1:0] win;
  logic             win_any;

  always_comb begin
    sel_tid_full = 1'b0;
    for (int t = 0; t < THREADS; t++)
      if (TID_W'(t) == req_tid) sel_tid_full = full_v[t];
  end

  assign req_ready = !req_spec || !sel_tid_full;
  assign cmt_ready = !sqh_valid;
  assign cmt_fire  = cmt_valid && cmt_ready;

  for (genvar t = 0; t < THREADS; t++) begin : g_thr
    ssb_thread_buf #(
      .THREAD_ID (t),
      .DEPTH     (DEPTH),
      .TID_W     (TID_W),
      .EPOCH_W   (EPOCH_W),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W)
    ) u_buf (
      .clk         (clk),
      .rst_n       (rst_n),
      .alloc_en    (req_valid && req_spec && req_ready && req_tid == TID_W'(t)),
      .alloc_tid   (req_tid),
      .alloc_epoch (req_epoch),
      .alloc_addr  (req_addr),
      .alloc_data  (req_data),
      .cmt_en      (cmt_fire && cmt_tid == TID_W'(t)),
      .cmt_epoch   (cmt_epoch),
      .sqh_en      (sqh_valid && sqh_tid == TID_W'(t)),
      .sqh_epoch   (sqh_epoch),
      .lk_addr     (req_addr),
      .lk_hit      (hit_v[t]),
      .lk_data     (lkd_a[t]),
      .full        (full_v[t]),
      .drain_valid (dv_v[t]),
      .drain_tid   (dtid_a[t]),
      .drain_addr  (daddr_a[t]),
      .drain_data  (ddata_a[t]),
      .drain_take  (take_v[t])
    );
    assign take_v[t] = load_fire && win == TID_W'(t);
  end

  // lookup result of the requesting thread, delayed by a fixed latency
  logic              lk_hit_sel;
  logic [DATA_W-1:0] lk_data_sel;
  always_comb begin
    lk_hit_sel  = 1'b0;
    lk_data_sel = '0;
    for (int t = 0; t < THREADS; t++) begin
      if (TID_W'(t) == req_tid) begin
        lk_hit_sel  = hit_v[t];
        lk_data_sel = lkd_a[t];
      end
    end
  end

  ssb_rsp_pipe #(.LAT(HIT_LAT), .DATA_W(DATA_W)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid && !req_spec),
    .in_hit    (lk_hit_sel),
    .in_data   (lk_data_sel),
    .out_valid (rsp_valid),
    .out_hit   (rsp_hit),
    .out_data  (rsp_data)
  );

  // replay arbitration: lowest thread number with a committed line
  always_comb begin
    win     = '0;
    win_any = 1'b0;
    for (int t = THREADS - 1; t >= 0; t--) begin
      if (dv_v[t]) begin
        win     = TID_W'(t);
        win_any = 1'b1;
      end
    end
  end

  logic              scv_q;
  logic [TID_W-1:0]  sct_q;
  logic [ADDR_W-1:0] sca_q;
  logic [DATA_W-1:0] scd_q;

  assign load_en   = !scv_q || sc_ready;
  assign load_fire = load_en && win_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scv_q <= 1'b0;
      sct_q <= '0;
      sca_q <= '0;
      scd_q <= '0;
    end else if (load_en) begin
      scv_q <= win_any;
      if (win_any) begin
        sct_q <= dtid_a[win];
        sca_q <= daddr_a[win];
        scd_q <= ddata_a[win];
      end
    end
  end

  assign sc_valid = scv_q;
  assign sc_tid   = sct_q;
  assign sc_addr  = sca_q;
  assign sc_data  = scd_q;

  assert_replay_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_valid && !sc_ready) |=> (sc_valid && $stable(sc_tid) && $stable(sc_addr)
                                 && $stable(sc_data)));
  assert_single_take_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_v));
  assert_take_has_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|take_v) |=> sc_valid);
endmodule

// File: tb/tb_spec_shadow_buf.sv
module tb_spec_shadow_buf;
  localparam int HIT_LAT = 2;
  localparam logic [2:0] OP_ALLOC = 3'd0, OP_CMT = 3'd1, OP_SQH = 3'd2,
                         OP_LOOK = 3'd3, OP_DRAIN = 3'd4, OP_EMPTY = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic        tid;
    logic [3:0]  ep;
    logic [15:0] addr;
    logic [31:0] data;
    logic        hit;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{OP_ALLOC, 1'b0, 4'd1, 16'h0100, 32'hA000_0100, 1'b0},
    '{OP_ALLOC, 1'b0, 4'd2, 16'h0200, 32'hA000_0200, 1'b0},
    '{OP_ALLOC, 1'b0, 4'd1, 16'h0300, 32'hA000_0300, 1'b0},
    '{OP_ALLOC, 1'b0, 4'd2, 16'h0400, 32'hA000_0400, 1'b0},
    '{OP_ALLOC, 1'b1, 4'd1, 16'h0500, 32'hB000_0500, 1'b0},
    '{OP_LOOK,  1'b0, 4'd0, 16'h0100, 32'h0,         1'b0},
    '{OP_EMPTY, 1'b0, 4'd0, 16'h0,    32'h0,         1'b0},
    '{OP_CMT,   1'b0, 4'd2, 16'h0,    32'h0,         1'b0},
    '{OP_LOOK,  1'b0, 4'd0, 16'h0400, 32'hA000_0400, 1'b1},
    '{OP_LOOK,  1'b1, 4'd0, 16'h0400, 32'h0,         1'b0},
    '{OP_CMT,   1'b0, 4'd1, 16'h0,    32'h0,         1'b0},
    '{OP_DRAIN, 1'b0, 4'd0, 16'h0200, 32'hA000_0200, 1'b0},
    '{OP_DRAIN, 1'b0, 4'd0, 16'h0100, 32'hA000_0100, 1'b0},
    '{OP_DRAIN, 1'b0, 4'd0, 16'h0300, 32'hA000_0300, 1'b0},
    '{OP_DRAIN, 1'b0, 4'd0, 16'h0400, 32'hA000_0400, 1'b0},
    '{OP_LOOK,  1'b0, 4'd0, 16'h0400, 32'h0,         1'b0},
    '{OP_SQH,   1'b1, 4'd1, 16'h0,    32'h0,         1'b0},
    '{OP_EMPTY, 1'b0, 4'd0, 16'h0,    32'h0,         1'b0},
    '{OP_LOOK,  1'b1, 4'd0, 16'h0500, 32'h0,         1'b0},
    '{OP_ALLOC, 1'b1, 4'd3, 16'h0600, 32'hB000_0600, 1'b0},
    '{OP_CMT,   1'b1, 4'd3, 16'h0,    32'h0,         1'b0},
    '{OP_DRAIN, 1'b1, 4'd0, 16'h0600, 32'hB000_0600, 1'b0},
    '{OP_EMPTY, 1'b0, 4'd0, 16'h0,    32'h0,         1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_spec = 1'b1;
  logic [0:0]  req_tid = '0;
  logic [3:0]  req_epoch = '0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_data = '0;
  logic        req_ready;
  logic        rsp_valid, rsp_hit;
  logic [31:0] rsp_data;
  logic        cmt_valid = 1'b0, cmt_ready;
  logic [0:0]  cmt_tid = '0;
  logic [3:0]  cmt_epoch = '0;
  logic        sqh_valid = 1'b0;
  logic [0:0]  sqh_tid = '0;
  logic [3:0]  sqh_epoch = '0;
  logic        sc_valid, sc_ready = 1'b0;
  logic [0:0]  sc_tid;
  logic [15:0] sc_addr;
  logic [31:0] sc_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spec_shadow_buf #(.HIT_LAT(HIT_LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_spec(req_spec),
    .req_tid(req_tid), .req_epoch(req_epoch), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .cmt_valid(cmt_valid), .cmt_ready(cmt_ready), .cmt_tid(cmt_tid), .cmt_epoch(cmt_epoch),
    .sqh_valid(sqh_valid), .sqh_tid(sqh_tid), .sqh_epoch(sqh_epoch),
    .sc_valid(sc_valid), .sc_ready(sc_ready), .sc_tid(sc_tid),
    .sc_addr(sc_addr), .sc_data(sc_data)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected end before 20000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_alloc(input logic tid, input logic [3:0] ep,
                          input logic [15:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_spec = 1'b1; req_tid = tid;
    req_epoch = ep; req_addr = a; req_data = d;
    #1 chk(req_ready == 1'b1, "R2 accept spec", 32'(req_ready), 32'd1);
    @(negedge clk) req_valid = 1'b0;
  endtask

  task automatic do_cmt(input logic tid, input logic [3:0] ep);
    cmt_valid = 1'b1; cmt_tid = tid; cmt_epoch = ep;
    @(negedge clk) cmt_valid = 1'b0;
  endtask

  task automatic do_sqh(input logic tid, input logic [3:0] ep);
    sqh_valid = 1'b1; sqh_tid = tid; sqh_epoch = ep;
    @(negedge clk) sqh_valid = 1'b0;
  endtask

  task automatic do_look(input logic tid, input logic [15:0] a,
                         input logic hit, input logic [31:0] d);
    req_valid = 1'b1; req_spec = 1'b0; req_tid = tid; req_addr = a;
    #1 chk(req_ready == 1'b1, "R3 nonspec ready", 32'(req_ready), 32'd1);
    @(negedge clk) req_valid = 1'b0; req_spec = 1'b1;
    chk(rsp_valid == 1'b0, "R7 no early rsp", 32'(rsp_valid), 32'd0);
    repeat (HIT_LAT - 1) @(negedge clk);
    chk(rsp_valid == 1'b1, "R7 rsp latency", 32'(rsp_valid), 32'd1);
    chk(rsp_hit == hit, "R7 R1 rsp hit", 32'(rsp_hit), 32'(hit));
    chk(rsp_data == (hit ? d : 32'h0), "R7 rsp data", rsp_data, hit ? d : 32'h0);
  endtask

  task automatic do_drain(input logic tid, input logic [15:0] a, input logic [31:0] d);
    for (int k = 0; k < 8 && !sc_valid; k++) @(negedge clk);
    chk(sc_valid == 1'b1, "R4 replay present", 32'(sc_valid), 32'd1);
    chk(sc_addr == a, "R4 replay order addr", 32'(sc_addr), 32'(a));
    chk(sc_data == d && sc_tid == tid, "R4 R1 replay data/tid", sc_data, d);
    sc_ready = 1'b1;
    @(negedge clk) sc_ready = 1'b0;
  endtask

  task automatic do_empty();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(sc_valid == 1'b0, "R2 R5 no replay", 32'(sc_valid), 32'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(sc_valid == 1'b0 && rsp_valid == 1'b0, "R9 outputs idle in reset",
        32'({sc_valid, rsp_valid}), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1 chk(req_ready == 1'b1 && cmt_ready == 1'b1, "R9 ready after reset",
           32'({req_ready, cmt_ready}), 32'd3);
    chk(sc_valid == 1'b0, "R9 no replay after reset", 32'(sc_valid), 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      case (VECS[v].op)
        OP_ALLOC: do_alloc(VECS[v].tid, VECS[v].ep, VECS[v].addr, VECS[v].data);
        OP_CMT:   do_cmt(VECS[v].tid, VECS[v].ep);
        OP_SQH:   do_sqh(VECS[v].tid, VECS[v].ep);
        OP_LOOK:  do_look(VECS[v].tid, VECS[v].addr, VECS[v].hit, VECS[v].data);
        OP_DRAIN: do_drain(VECS[v].tid, VECS[v].addr, VECS[v].data);
        default:  do_empty();
      endcase
    end

    // R3 full thread stalls, other thread does not, squash frees space
    for (int i = 0; i < 8; i++) do_alloc(1'b0, 4'd5, 16'h1000 + 16'(i), 32'hC000_0000 + 32'(i));
    req_valid = 1'b1; req_spec = 1'b1; req_tid = 1'b0; req_epoch = 4'd5; req_addr = 16'h1100;
    #1 chk(req_ready == 1'b0, "R3 stall when full", 32'(req_ready), 32'd0);
    req_spec = 1'b0;
    #1 chk(req_ready == 1'b1, "R3 nonspec not stalled", 32'(req_ready), 32'd1);
    req_spec = 1'b1; req_tid = 1'b1;
    #1 chk(req_ready == 1'b1, "R1 other thread not stalled", 32'(req_ready), 32'd1);
    req_valid = 1'b0; req_tid = 1'b0;
    @(negedge clk);
    do_sqh(1'b0, 4'd5);
    #1 chk(req_ready == 1'b1, "R3 ready after squash", 32'(req_ready), 32'd1);
    do_empty();
    do_look(1'b0, 16'h1003, 1'b0, 32'h0);

    // R6 squash and commit together
    do_alloc(1'b0, 4'd6, 16'h3000, 32'hD000_3000);
    do_alloc(1'b0, 4'd7, 16'h3100, 32'hD000_3100);
    sqh_valid = 1'b1; sqh_tid = 1'b0; sqh_epoch = 4'd6;
    cmt_valid = 1'b1; cmt_tid = 1'b0; cmt_epoch = 4'd7;
    #1 chk(cmt_ready == 1'b0, "R6 commit blocked by squash", 32'(cmt_ready), 32'd0);
    @(negedge clk) sqh_valid = 1'b0; cmt_valid = 1'b0;
    do_empty();
    do_look(1'b0, 16'h3100, 1'b0, 32'h0);
    do_cmt(1'b0, 4'd7);
    do_drain(1'b0, 16'h3100, 32'hD000_3100);
    do_empty();

    // R10 allocation meeting squash / commit of its own epoch
    req_valid = 1'b1; req_spec = 1'b1; req_tid = 1'b0; req_epoch = 4'd8;
    req_addr = 16'h2000; req_data = 32'hE000_2000;
    sqh_valid = 1'b1; sqh_tid = 1'b0; sqh_epoch = 4'd8;
    @(negedge clk) req_valid = 1'b0; sqh_valid = 1'b0;
    do_cmt(1'b0, 4'd8);
    do_empty();
    req_valid = 1'b1; req_epoch = 4'd9; req_addr = 16'h2100; req_data = 32'hE000_2100;
    cmt_valid = 1'b1; cmt_tid = 1'b0; cmt_epoch = 4'd9;
    @(negedge clk) req_valid = 1'b0; cmt_valid = 1'b0;
    for (int k = 0; k < 8 && !sc_valid; k++) @(negedge clk);
    chk(sc_valid == 1'b1 && sc_addr == 16'h2100, "R10 same-cycle commit kept",
        32'(sc_addr), 32'h2100);
    // R8 hold under back-pressure
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(sc_valid == 1'b1 && sc_addr == 16'h2100 && sc_data == 32'hE000_2100,
          "R8 replay held", sc_data, 32'hE000_2100);
    end
    do_drain(1'b0, 16'h2100, 32'hE000_2100);
    do_empty();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule